// File: doc/BRIEF.md
# Oversampling Averaging Accumulator

This block sits between the sample output of an analog-to-digital converter and the result register that software reads. A trigger opens a batch. The block sums a programmable number of 12-bit samples into a 20-bit running total. When the batch is complete, it shifts the total right by a programmable amount and keeps the low 16 bits as the result. The end-of-conversion flag is raised only when that averaged value is ready; single samples inside a batch never raise it.

The ratio and shift settings are captured when a batch starts, so changing them mid-batch has no effect on that batch. Reading the result clears the end-of-conversion flag.

In auto-delay mode, a trigger is dropped while an unread result is pending, so a result can never be overwritten. Without auto-delay, a new result that completes before the old one was read overwrites it and sets the overrun flag.

Top module: `ovs_avg_top`

## Requirements
- R1: After reset `dataOut` is 0 and `eocFlag`, `ovrFlag` and `busy` are 0.
- R2: A `ratioSel` value k makes a batch take exactly 2^(k+1) accepted samples (0 gives 2, 7 gives 256). `busy` is 1 from the cycle after an accepted trigger until the edge that takes the last sample.
- R3: A `shiftSel` value s shifts the batch total right by s bits for s in 0..8, and by 8 bits for any s from 9 to 15. `dataOut` is bits 15..0 of the shifted total; higher bits are dropped.
- R4: The total is kept in 20 bits, enough for 256 full-scale samples, and starts from zero at every batch, so nothing carries from one batch into the next.
- R5: `eocFlag` rises in the cycle after the last sample of a batch and not after any earlier sample. `dataOut` changes only at that point.
- R6: A `readAck` pulse clears `eocFlag` and `ovrFlag`, except when a batch completes in the same cycle; in that case `eocFlag` stays 1.
- R7: With `autoDelay` = 1, a trigger that arrives while `eocFlag` is 1 is ignored. `busy` stays 0 and the samples that follow are not taken.
- R8: With `autoDelay` = 0, a batch that completes while `eocFlag` is still 1 and no `readAck` is present sets `ovrFlag` and replaces `dataOut` with the new result.
- R9: A trigger that arrives while `busy` is 1 is ignored. Samples that arrive while `busy` is 0 are not accumulated.
- R10: `ratioSel` and `shiftSel` are captured at the accepted trigger. Changes made during a batch apply only to the next batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Request to start a batch |
| sampleIn | input | 12 | Right-aligned raw sample |
| sampleValid | input | 1 | `sampleIn` carries a new sample this cycle |
| ratioSel | input | 3 | Samples per batch, 2^(ratioSel+1) |
| shiftSel | input | 4 | Right shift of the total, clamped at 8 |
| autoDelay | input | 1 | Drop triggers while a result is unread |
| readAck | input | 1 | Result has been read; clears the flags |
| dataOut | output | 16 | Averaged result |
| eocFlag | output | 1 | Averaged result ready |
| ovrFlag | output | 1 | Unread result was overwritten |
| busy | output | 1 | Batch in progress |

## Verification
The bench builds the block with its default parameters: 12-bit samples, a 20-bit total, 16-bit results, a 3-bit ratio field and a clamp at 8. With these values the largest ratio of 256 is reachable within the run time. Full-scale samples at that ratio fill the total to 0xFFF00. This exercises both the truncation of high bits at small shifts and the clamp of out-of-range shifts. Short ratios of 2 and 4 keep the handshake scenarios (overrun, dropped triggers and mid-batch setting changes) brief enough to check cycle by cycle.

// File: rtl/ovs_avg_pkg.sv
package ovs_avg_pkg;
  typedef struct packed {
    logic startBatch;
    logic addSample;
    logic lastSample;
  } ovsStrobe_t;
endpackage

// File: rtl/ovs_avg_ctrl.sv
module ovs_avg_ctrl
  import ovs_avg_pkg::*;
#(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigIn,
  input  logic               sampleValid,
  input  logic [RATIO_W-1:0] ratioSel,
  input  logic               autoDelay,
  input  logic               readAck,
  output ovsStrobe_t         strb,
  output logic               busy,
  output logic               eocFlag,
  output logic               ovrFlag
);
  localparam int CNT_W = (1 << RATIO_W) + 1;

  logic             busyQ, eocQ, ovrQ;
  logic [CNT_W-1:0] cntQ, lastIdxQ, lastIdxNext;
  logic [CNT_W-1:0] oneV;

  assign oneV        = CNT_W'(1);
  assign lastIdxNext = (oneV << (CNT_W'(ratioSel) + oneV)) - oneV;

  assign strb.startBatch = trigIn && !busyQ && !(autoDelay && eocQ);
  assign strb.addSample  = busyQ && sampleValid;
  assign strb.lastSample = strb.addSample && (cntQ == lastIdxQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      cntQ     <= '0;
      lastIdxQ <= '0;
      eocQ     <= 1'b0;
      ovrQ     <= 1'b0;
    end else begin
      if (strb.startBatch) begin
        busyQ    <= 1'b1;
        cntQ     <= '0;
        lastIdxQ <= lastIdxNext;
      end else if (strb.lastSample) begin
        busyQ <= 1'b0;
        cntQ  <= '0;
      end else if (strb.addSample) begin
        cntQ <= cntQ + oneV;
      end

      if (strb.lastSample)  eocQ <= 1'b1;
      else if (readAck)     eocQ <= 1'b0;

      if (strb.lastSample && eocQ && !readAck) ovrQ <= 1'b1;
      else if (readAck)                        ovrQ <= 1'b0;
    end
  end

  assign busy    = busyQ;
  assign eocFlag = eocQ;
  assign ovrFlag = ovrQ;

  // R7
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoDelay && eocQ && !busyQ) |=> !busyQ);

  // R5
  eoc_on_batch_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eocQ) |-> $past(busyQ));

  // R8
  ovr_needs_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrQ) |-> ($past(eocQ) && eocQ));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readAck && !strb.lastSample) |=> (!eocQ && !ovrQ));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (cntQ <= lastIdxQ));
endmodule

// File: rtl/ovs_avg_dpath.sv
module ovs_avg_dpath
  import ovs_avg_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int ACC_W     = 20,
  parameter int OUT_W     = 16,
  parameter int SHIFT_W   = 4,
  parameter int MAX_SHIFT = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ovsStrobe_t          strb,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [SHIFT_W-1:0]  shiftSel,
  output logic [OUT_W-1:0]    dataOut
);
  localparam logic [SHIFT_W-1:0] SHIFT_CAP = SHIFT_W'(MAX_SHIFT);

  logic [ACC_W-1:0]   accQ, accNext, shifted;
  logic [SHIFT_W-1:0] shiftQ, shiftClamped;
  logic [OUT_W-1:0]   dataQ;

  assign shiftClamped = (shiftSel > SHIFT_CAP) ? SHIFT_CAP : shiftSel;
  assign accNext      = accQ + ACC_W'(sampleIn);
  assign shifted      = accNext >> shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ   <= '0;
      shiftQ <= '0;
      dataQ  <= '0;
    end else begin
      if (strb.startBatch) begin
        accQ   <= '0;
        shiftQ <= shiftClamped;
      end else if (strb.addSample) begin
        accQ <= accNext;
      end
      if (strb.lastSample) dataQ <= shifted[OUT_W-1:0];
    end
  end

  assign dataOut = dataQ;

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.lastSample) |-> $stable(dataQ));

  // R3
  shift_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftQ <= SHIFT_CAP);
endmodule

// File: rtl/ovs_avg_top.sv
module ovs_avg_top
  import ovs_avg_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int ACC_W     = 20,
  parameter int OUT_W     = 16,
  parameter int RATIO_W   = 3,
  parameter int SHIFT_W   = 4,
  parameter int MAX_SHIFT = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trigIn,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic [RATIO_W-1:0]  ratioSel,
  input  logic [SHIFT_W-1:0]  shiftSel,
  input  logic                autoDelay,
  input  logic                readAck,
  output logic [OUT_W-1:0]    dataOut,
  output logic                eocFlag,
  output logic                ovrFlag,
  output logic                busy
);
  ovsStrobe_t strb;

  ovs_avg_ctrl #(.RATIO_W(RATIO_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .sampleValid(sampleValid),
    .ratioSel(ratioSel), .autoDelay(autoDelay), .readAck(readAck),
    .strb(strb), .busy(busy), .eocFlag(eocFlag), .ovrFlag(ovrFlag)
  );

  ovs_avg_dpath #(
    .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .OUT_W(OUT_W),
    .SHIFT_W(SHIFT_W), .MAX_SHIFT(MAX_SHIFT)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleIn(sampleIn),
    .shiftSel(shiftSel), .dataOut(dataOut)
  );
endmodule

// File: tb/ovs_avg_top_tb_top.sv
module ovs_avg_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigIn = 1'b0;
  logic [11:0] sampleIn = '0;
  logic        sampleValid = 1'b0;
  logic [2:0]  ratioSel = '0;
  logic [3:0]  shiftSel = '0;
  logic        autoDelay = 1'b0;
  logic        readAck = 1'b0;
  logic [15:0] dataOut;
  logic        eocFlag, ovrFlag, busy;

  int checks = 0;
  int errors = 0;
  int sumAcc = 0;

  always #10 clk = ~clk;

  ovs_avg_top dut_i (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .sampleIn(sampleIn),
    .sampleValid(sampleValid), .ratioSel(ratioSel), .shiftSel(shiftSel),
    .autoDelay(autoDelay), .readAck(readAck), .dataOut(dataOut),
    .eocFlag(eocFlag), .ovrFlag(ovrFlag), .busy(busy)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int expAvg(int sum, int sh);
    int s = (sh > 8) ? 8 : sh;
    return (sum >> s) & 16'hFFFF;
  endfunction

  task automatic pulseTrig();
    @(negedge clk); trigIn = 1'b1;
    @(negedge clk); trigIn = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk); readAck = 1'b1;
    @(negedge clk); readAck = 1'b0;
  endtask

  // feeds n back-to-back samples starting at the current negedge
  task automatic feed(int n, int base, int step);
    for (int i = 0; i < n; i++) begin
      sampleIn = 12'((base + i * step) & 12'hFFF);
      sampleValid = 1'b1;
      sumAcc += (base + i * step) & 12'hFFF;
      @(negedge clk);
    end
    sampleValid = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 dataOut", dataOut, 0);
    chk("R1 eocFlag", eocFlag, 0);
    chk("R1 ovrFlag", ovrFlag, 0);
    chk("R1 busy", busy, 0);
  endtask

  task automatic tSmallBatch();
    ratioSel = 3'd0; shiftSel = 4'd1; sumAcc = 0;
    pulseTrig();
    chk("R2 busy after trigger", busy, 1);
    feed(1, 12'h301, 0);
    chk("R5 no eoc mid batch", eocFlag, 0);
    chk("R2 busy mid batch", busy, 1);
    feed(1, 12'h0FE, 0);
    chk("R5 eoc at end", eocFlag, 1);
    chk("R2 idle at end", busy, 0);
    chk("R3 shift 1 result", dataOut, expAvg(sumAcc, 1));
    pulseAck();
    chk("R6 eoc cleared", eocFlag, 0);
  endtask

  task automatic tFullScale(int sh, string tag);
    ratioSel = 3'd7; shiftSel = 4'(sh); sumAcc = 0;
    pulseTrig();
    feed(255, 12'hFFF, 0);
    chk({tag, " busy before 256th"}, busy, 1);
    feed(1, 12'hFFF, 0);
    chk({tag, " eoc"}, eocFlag, 1);
    chk({tag, " result"}, dataOut, expAvg(sumAcc, sh));
    pulseAck();
  endtask

  task automatic tFreshBatch();
    ratioSel = 3'd1; shiftSel = 4'd0; sumAcc = 0;
    pulseTrig();
    feed(4, 12'h010, 12'h003);
    chk("R4 sum restarts", dataOut, expAvg(sumAcc, 0));
    pulseAck();
  endtask

  task automatic tAutoDelay();
    int held;
    autoDelay = 1'b1; ratioSel = 3'd0; shiftSel = 4'd0; sumAcc = 0;
    pulseTrig();
    feed(2, 12'h111, 12'h001);
    held = dataOut;
    chk("R7 eoc pending", eocFlag, 1);
    pulseTrig();
    chk("R7 trigger dropped", busy, 0);
    feed(2, 12'h777, 0);
    chk("R7 data unchanged", dataOut, held);
    chk("R7 no overrun", ovrFlag, 0);
    pulseAck();
    sumAcc = 0;
    pulseTrig();
    chk("R7 trigger after read", busy, 1);
    feed(2, 12'h222, 0);
    chk("R7 new result", dataOut, expAvg(sumAcc, 0));
    pulseAck();
    autoDelay = 1'b0;
  endtask

  task automatic tOverrun();
    ratioSel = 3'd0; shiftSel = 4'd0; sumAcc = 0;
    pulseTrig();
    feed(2, 12'h100, 0);
    chk("R8 no ovr first", ovrFlag, 0);
    sumAcc = 0;
    pulseTrig();
    chk("R8 trigger accepted", busy, 1);
    feed(2, 12'h345, 12'h010);
    chk("R8 ovr set", ovrFlag, 1);
    chk("R8 data overwritten", dataOut, expAvg(sumAcc, 0));
    pulseAck();
    chk("R6 ovr cleared", ovrFlag, 0);
    chk("R6 eoc cleared", eocFlag, 0);
  endtask

  task automatic tIgnored();
    ratioSel = 3'd1; shiftSel = 4'd0;
    @(negedge clk);
    feed(3, 12'hFFF, 0);
    sumAcc = 0;
    pulseTrig();
    feed(2, 12'h020, 12'h001);
    @(negedge clk); trigIn = 1'b1;
    @(negedge clk); trigIn = 1'b0;
    feed(1, 12'h050, 0);
    chk("R9 still busy", busy, 1);
    feed(1, 12'h060, 0);
    chk("R9 batch done", busy, 0);
    chk("R9 idle samples dropped", dataOut, expAvg(sumAcc, 0));
    pulseAck();
  endtask

  task automatic tCapture();
    ratioSel = 3'd1; shiftSel = 4'd2; sumAcc = 0;
    pulseTrig();
    ratioSel = 3'd0; shiftSel = 4'd0;
    feed(2, 12'h400, 12'h011);
    chk("R10 ratio held", busy, 1);
    feed(2, 12'h123, 0);
    chk("R10 eoc", eocFlag, 1);
    chk("R10 shift held", dataOut, expAvg(sumAcc, 2));
    pulseAck();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSmallBatch();
    tFullScale(4, "R2 ratio 256");
    tFullScale(0, "R3 truncate");
    tFullScale(12, "R3 clamp");
    tFreshBatch();
    tAutoDelay();
    tOverrun();
    tIgnored();
    tCapture();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 50000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule